// File: doc/BRIEF.md
# Normalized Float-to-Fixed Packer

This block takes up to four IEEE single-precision values and turns them into a single 32-bit word of normalized fixed-point fields. A 2-bit format code selects one of four formats. The fields are either signed or unsigned, and there are either two 16-bit lanes or four 8-bit lanes. Each lane clamps its input to the normalized range and scales it by the largest code its field can hold. It then rounds to the nearest integer and drops the result into its slot in the word. The scaling is done on the raw float bits with an integer multiply-and-shift, so the block needs no floating-point unit.

The result and its valid flag leave the block from one register stage. A producer presents the four lanes with the format code and a valid strobe. The consumer sees the packed word one clock later. When the strobe is low, the word stays as it was.

Top module: `fp_norm_packer`

## Requirements
- R1: `in_fmt` selects the format: 0 = signed two 16-bit lanes, 1 = signed four 8-bit lanes, 2 = unsigned two 16-bit lanes, 3 = unsigned four 8-bit lanes. Lane i's result sits at bits [16i+15:16i] in 16-bit formats and at bits [8i+7:8i] in 8-bit formats. Lane i is `in_flt[32i+31:32i]`.
- R2: In signed formats, a lane is clamped to [-1.0, +1.0] and multiplied by 32767 (16-bit) or 127 (8-bit). Values of magnitude 1.0 or more, infinities included, give ±32767 / ±127.
- R3: In unsigned formats, a lane is clamped to [0.0, 1.0] and multiplied by 65535 (16-bit) or 255 (8-bit). Any negative input, including -0.0 and -infinity, gives 0.
- R4: The scaled value is rounded to the nearest integer, and an exact half goes to the even neighbour. For example, 0.5 gives 16384, 64, 32768 and 128 in formats 0, 1, 2 and 3.
- R5: Signed results are stored as two's complement cut to the lane width. For example, -1.0 gives 0x8001 in a 16-bit lane and 0x81 in an 8-bit lane, and the most negative code never appears.
- R6: A NaN lane (exponent all ones, fraction non-zero) gives a code of 0.
- R7: A lane whose biased exponent is 0 (zero or subnormal) gives a code of 0.
- R8: In the 16-bit formats, lanes 2 and 3 have no effect on the word.
- R9: `out_word` and `out_valid` are updated on the first rising clock edge after the inputs are sampled. `out_valid` is `in_valid` delayed by exactly one cycle.
- R10: In a cycle with `in_valid` low, `out_word` keeps its previous value and `out_valid` goes low on the next edge.
- R11: A synchronous active-low reset clears `out_word` to 0 and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input lanes and format are valid this cycle |
| in_fmt | input | 2 | Format code (R1) |
| in_flt | input | 128 | Four single-precision lanes, lane 0 in the low bits |
| out_valid | output | 1 | `out_word` carries a fresh result |
| out_word | output | 32 | Packed fixed-point word |

## Verification
Every result is due exactly one rising edge after the cycle in which its inputs were sampled. The bench drives inputs on a falling edge and reads the word and the valid flag on the next falling edge. That places the read after one register stage and before any later one. Hold cases use the same spacing: a low strobe is driven with new data, and the old word must still be there on the following falling edge. Reset is checked on the falling edge after a reset edge.

// File: rtl/fpnp_pkg.sv
// Package: shared constants and the format code for the normalized packer.
// Assumes IEEE single-precision inputs with a biased exponent.
package fpnp_pkg;
    localparam int FLT_W = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int BIAS  = 127;

    typedef enum logic [1:0] {
        FMT_S16 = 2'd0,
        FMT_S8  = 2'd1,
        FMT_U16 = 2'd2,
        FMT_U8  = 2'd3
    } pack_fmt_e;
endpackage

// File: rtl/fpnp_lane.sv
// Module: one lane converter. Clamps, scales by 2^n-1 and rounds half-to-even
// a single float on its raw bits, with integer arithmetic only.
// Assumes: signed_i/narrow_i come from the format code; in narrow mode only
// the low NARROW_W bits of code_o are meaningful.
module fpnp_lane
    import fpnp_pkg::*;
#(
    parameter int CODE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [FLT_W-1:0]  flt_i,
    input  logic              signed_i,
    input  logic              narrow_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = SIG_W + CODE_W;
    localparam int CAP    = PROD_W + 1;
    localparam int FB_W   = $clog2(CODE_W + 1);
    localparam int SH_W   = EXP_W + 1;

    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [MAN_W-1:0]  man;
    logic              is_nan, is_tiny, is_big;
    logic [FB_W-1:0]   fbits;
    logic [PROD_W-1:0] sig_x, prod, q, gsh, mask;
    logic [SH_W-1:0]   shamt_raw, rs;
    logic              guard, sticky, rnd;
    logic [CODE_W:0]   kmax, mag, res;

    assign sgn = flt_i[FLT_W-1];
    assign ex  = flt_i[FLT_W-2 -: EXP_W];
    assign man = flt_i[MAN_W-1:0];

    // Classify the input: NaN, zero/subnormal, or magnitude of at least 1.0.
    always_comb begin
        is_nan  = (ex == {EXP_W{1'b1}}) && (man != '0);
        is_tiny = (ex == '0);
        is_big  = (ex >= EXP_W'(BIAS));
    end

    // Choose the number of fraction bits n from the format, so the scale is 2^n-1.
    always_comb begin
        case ({narrow_i, signed_i})
            2'b00:   fbits = FB_W'(CODE_W);
            2'b01:   fbits = FB_W'(CODE_W - 1);
            2'b10:   fbits = FB_W'(NARROW_W);
            default: fbits = FB_W'(NARROW_W - 1);
        endcase
        kmax = ({{CODE_W{1'b0}}, 1'b1} << fbits) - {{CODE_W{1'b0}}, 1'b1};
    end

    // Multiply the significand by 2^n-1 as a shift and a subtract.
    always_comb begin
        sig_x = PROD_W'({1'b1, man});
        prod  = (sig_x << fbits) - sig_x;
    end

    // Align to the integer point, then round half-to-even on guard and sticky bits.
    always_comb begin
        shamt_raw = SH_W'(BIAS + MAN_W) - {1'b0, ex};
        rs        = (shamt_raw > SH_W'(CAP)) ? SH_W'(CAP) : shamt_raw;
        q         = prod >> rs;
        gsh       = prod >> (rs - SH_W'(1));
        guard     = gsh[0];
        mask      = (PROD_W'(1) << (rs - SH_W'(1))) - PROD_W'(1);
        sticky    = |(prod & mask);
        rnd       = guard & (sticky | q[0]);
    end

    // Select the magnitude, apply the sign or the unsigned floor, and cut to the lane.
    always_comb begin
        if (is_nan || is_tiny)
            mag = '0;
        else if (is_big)
            mag = kmax;
        else
            mag = q[CODE_W:0] + {{CODE_W{1'b0}}, rnd};
        if (sgn)
            res = signed_i ? (~mag + {{CODE_W{1'b0}}, 1'b1}) : '0;
        else
            res = mag;
        code_o = res[CODE_W-1:0];
    end

    // Checks for R2, R3 and R5 on the settled lane result.
    always_comb begin
        a_r2_mag_bound: assert (mag <= kmax);
        if (!signed_i && narrow_i)
            a_r3_unsigned_narrow_fits: assert (code_o[CODE_W-1:NARROW_W] == '0);
        if (signed_i && !narrow_i)
            a_r5_no_min_wide: assert (code_o != {1'b1, {(CODE_W-1){1'b0}}});
        if (signed_i && narrow_i)
            a_r5_no_min_narrow: assert (code_o[NARROW_W-1:0] != {1'b1, {(NARROW_W-1){1'b0}}});
    end
endmodule

// File: rtl/fpnp_assemble.sv
// Module: places the lane codes into the output word. In narrow formats every
// lane gives its low NARROW_W bits; in wide formats the first lanes give CODE_W bits each.
// Assumes: LANES*NARROW_W == WORD_W and CODE_W divides WORD_W.
module fpnp_assemble #(
    parameter int LANES    = 4,
    parameter int CODE_W   = 16,
    parameter int NARROW_W = 8,
    parameter int WORD_W   = 32
) (
    input  logic [LANES*CODE_W-1:0] codes_i,
    input  logic                    narrow_i,
    output logic [WORD_W-1:0]       word_o
);
    localparam int WIDE_LANES = WORD_W / CODE_W;

    logic [WORD_W-1:0] word_narrow, word_wide;

    // Narrow packing: lane i goes to bits [i*NARROW_W +: NARROW_W].
    for (genvar i = 0; i < LANES; i++) begin : g_narrow
        assign word_narrow[i*NARROW_W +: NARROW_W] = codes_i[i*CODE_W +: NARROW_W];
    end

    // Wide packing: lane i goes to bits [i*CODE_W +: CODE_W]; later lanes are dropped.
    for (genvar i = 0; i < WIDE_LANES; i++) begin : g_wide
        assign word_wide[i*CODE_W +: CODE_W] = codes_i[i*CODE_W +: CODE_W];
    end

    // Pick the layout that matches the format width.
    always_comb word_o = narrow_i ? word_narrow : word_wide;
endmodule

// File: rtl/fp_norm_packer.sv
// Module: top of the normalized float-to-fixed packer. Converts LANES floats
// in parallel and registers the packed word with its valid flag.
// Assumes: synchronous active-low reset; format code as in fpnp_pkg.
module fp_norm_packer
    import fpnp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             in_fmt,
    input  logic [LANES*FLT_W-1:0] in_flt,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_word
);
    localparam int CODE_W   = WORD_W / 2;
    localparam int NARROW_W = WORD_W / LANES;

    logic                    fmt_signed, fmt_narrow;
    logic [LANES*CODE_W-1:0] codes;
    logic [WORD_W-1:0]       word_next;

    // Decode the format code into signedness and lane width.
    always_comb begin
        fmt_signed = (in_fmt == FMT_S16) || (in_fmt == FMT_S8);
        fmt_narrow = (in_fmt == FMT_S8)  || (in_fmt == FMT_U8);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpnp_lane #(
            .CODE_W   (CODE_W),
            .NARROW_W (NARROW_W)
        ) u_lane (
            .flt_i    (in_flt[i*FLT_W +: FLT_W]),
            .signed_i (fmt_signed),
            .narrow_i (fmt_narrow),
            .code_o   (codes[i*CODE_W +: CODE_W])
        );
    end

    fpnp_assemble #(
        .LANES    (LANES),
        .CODE_W   (CODE_W),
        .NARROW_W (NARROW_W),
        .WORD_W   (WORD_W)
    ) u_assemble (
        .codes_i  (codes),
        .narrow_i (fmt_narrow),
        .word_o   (word_next)
    );

    // Output register: the word loads on valid input, and the flag follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= word_next;
        end
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));
    a_r6_nan_lane0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == FMT_U16 && in_flt[30:23] == 8'hFF && in_flt[22:0] != '0)
        |=> (out_word[CODE_W-1:0] == '0));
endmodule

// File: tb/fp_norm_packer_tb.sv
`timescale 1ns/1ps
module fp_norm_packer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_fmt = 2'd0;
    logic [127:0] in_flt = '0;
    logic         out_valid;
    logic [31:0]  out_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [31:0] P_ONE  = 32'h3F80_0000;
    localparam logic [31:0] N_ONE  = 32'hBF80_0000;
    localparam logic [31:0] P_HALF = 32'h3F00_0000;
    localparam logic [31:0] N_HALF = 32'hBF00_0000;
    localparam logic [31:0] P_TWO  = 32'h4000_0000;
    localparam logic [31:0] Q_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] P_INF  = 32'h7F80_0000;
    localparam logic [31:0] N_INF  = 32'hFF80_0000;
    localparam logic [31:0] SUBN   = 32'h0000_0001;
    localparam logic [31:0] N_ZERO = 32'h8000_0000;

    always #2.5 clk = ~clk;

    fp_norm_packer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_fmt    (in_fmt),
        .in_flt    (in_flt),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // Reference for one lane, computed with real arithmetic from the requirements.
    function automatic logic [15:0] ref_lane(input logic [31:0] f, input logic [1:0] fmt);
        int  k;
        real v;
        real x;
        int  fl;
        real fr;
        int  r;
        int  e;
        k = fmt[0] ? (fmt[1] ? 255 : 127) : (fmt[1] ? 65535 : 32767);
        e = int'(f[30:23]);
        if (e == 255 && f[22:0] != 0) return 16'h0;
        if (e == 0) return 16'h0;
        if (e == 255) v = 1.0;
        else begin
            v = 1.0 + real'(f[22:0]) / 8388608.0;
            for (int j = 0; j < e - 127; j++) v = v * 2.0;
            for (int j = 0; j < 127 - e; j++) v = v * 0.5;
        end
        if (v > 1.0) v = 1.0;
        x  = v * real'(k);
        fl = $rtoi(x);
        fr = x - real'(fl);
        r  = fl;
        if (fr > 0.5 || (fr == 0.5 && (fl % 2) == 1)) r = fl + 1;
        if (f[31]) r = fmt[1] ? 0 : -r;
        return 16'(r);
    endfunction

    function automatic logic [31:0] ref_word(input logic [1:0] fmt, input logic [127:0] fl);
        logic [15:0] l0, l1, l2, l3;
        l0 = ref_lane(fl[31:0], fmt);
        l1 = ref_lane(fl[63:32], fmt);
        l2 = ref_lane(fl[95:64], fmt);
        l3 = ref_lane(fl[127:96], fmt);
        if (fmt[0]) return {l3[7:0], l2[7:0], l1[7:0], l0[7:0]};
        return {l1, l0};
    endfunction

    task automatic check(input string req, input logic [31:0] act_w, input logic [31:0] exp_w,
                         input logic act_v, input logic exp_v);
        n_checks++;
        if (act_w !== exp_w || act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                     req, act_w, act_v, exp_w, exp_v);
        end
    endtask

    // Drive one input set on a falling edge; check the result on the next falling edge.
    task automatic apply(input string req, input logic [1:0] fmt, input logic [127:0] fl,
                         input logic vld, input logic [31:0] exp_w);
        @(negedge clk);
        in_fmt   = fmt;
        in_flt   = fl;
        in_valid = vld;
        @(negedge clk);
        check(req, out_word, exp_w, out_valid, vld);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: word=%h valid=%b expected completion", out_word, out_valid);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_flt = {4{P_ONE}};
        repeat (3) @(negedge clk);
        // R11: reset clears the word and the flag even with a valid strobe.
        check("R11", out_word, 32'h0, out_valid, 1'b0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R2 R5: signed 16-bit, +1.0 and -1.0.
        apply("R5", 2'd0, {P_ONE, P_ONE, N_ONE, P_ONE}, 1'b1, 32'h8001_7FFF);
        // R1 R4 R5: signed 8-bit lane order, ties at +/-0.5.
        apply("R1", 2'd1, {N_HALF, P_HALF, N_ONE, P_ONE}, 1'b1, 32'hC040_817F);
        // R3 R4: unsigned 16-bit, 0.5 ties to even, 2.0 clamps.
        apply("R4", 2'd2, {P_ONE, P_ONE, P_TWO, P_HALF}, 1'b1, 32'hFFFF_8000);
        // R3 R6 R7: unsigned 8-bit, negative, NaN, subnormal, +inf.
        apply("R6", 2'd3, {P_INF, SUBN, Q_NAN, N_ONE}, 1'b1, 32'hFF00_0000);
        // R2 R6: signed 16-bit, -inf clamps, NaN is zero.
        apply("R2", 2'd0, {32'h0, 32'h0, N_INF, Q_NAN}, 1'b1, 32'h8001_0000);
        // R7 R3: -0.0 and subnormal in signed 8-bit, and 0.5 in unsigned 8-bit.
        apply("R7", 2'd1, {P_ONE, SUBN, N_ZERO, SUBN}, 1'b1, 32'h7F00_0000);
        apply("R4", 2'd3, {32'h0, 32'h0, 32'h0, P_HALF}, 1'b1, 32'h0000_0080);
        // R8: in a 16-bit format, junk in lanes 2 and 3 changes nothing.
        apply("R8", 2'd2, {Q_NAN, P_ONE, 32'h0, P_ONE}, 1'b1, 32'h0000_FFFF);
        // R10: valid low with new data keeps the old word.
        held = out_word;
        apply("R10", 2'd0, {4{N_ONE}}, 1'b0, held);
        // R9: back-to-back valid inputs land one cycle after each.
        @(negedge clk);
        in_fmt = 2'd0; in_flt = {64'h0, P_HALF, P_ONE}; in_valid = 1'b1;
        @(negedge clk);
        check("R9", out_word, 32'h4000_7FFF, out_valid, 1'b1);
        in_fmt = 2'd1; in_flt = {P_ONE, N_ONE, P_ONE, N_ONE};
        @(negedge clk);
        check("R9", out_word, 32'h7F81_7F81, out_valid, 1'b1);
        in_valid = 1'b0;

        // R1 R2 R3 R4: random lanes against the reference model.
        for (int it = 0; it < 600; it++) begin
            logic [1:0]   fmt;
            logic [127:0] fl;
            fmt = 2'($urandom % 4);
            for (int ln = 0; ln < 4; ln++) begin
                logic [31:0] f;
                int cls;
                cls = int'($urandom % 8);
                f = $urandom;
                if (cls < 5) f[30:23] = 8'(100 + ($urandom % 30));
                else if (cls == 5) f[30:23] = 8'(120 + ($urandom % 8));
                else if (cls == 6) f = ($urandom % 2 == 0) ? P_HALF : N_HALF;
                fl[ln*32 +: 32] = f;
            end
            apply("R4", fmt, fl, 1'b1, ref_word(fmt, fl));
        end

        // R11: reset in mid-run clears again.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", out_word, 32'h0, out_valid, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule